// File: doc/BRIEF.md
# Associative TLB address translator

This block turns a virtual address into a physical address through a small, fully associative translation buffer. The virtual address is split into a page number (upper bits) and a byte offset within the page (lower bits). The page number is compared against every valid entry at once. When one matches, the physical address is the stored frame number placed above the unchanged offset. When none matches, a miss is reported so that a page-table walker outside this block can fetch the mapping and load it through the refill port.

Every entry holds read, write and execute permission bits, as well as referenced and modified bits that the hardware maintains. A lookup that matches but asks for an access the permissions do not allow is reported as a protection fault, which is separate from a miss. Such a lookup leaves the entry's bits as they were. Refills go into the slot named by a round-robin pointer. A flush input invalidates the whole buffer in one cycle.

Top module: `vpage_xlat`

## Requirements
- R1: On a hit, `rsp_paddr` equals the matching entry's frame number in bits [PA_W-1:OFF_W] and the request's offset bits [OFF_W-1:0] copied unchanged into the low bits.
- R2: A request sampled with `req_valid` high at a clock edge produces `rsp_valid` high after that edge and for exactly one cycle. `rsp_hit`, `rsp_miss` and `rsp_fault` are low whenever `rsp_valid` is low.
- R3: A response has exactly one of `rsp_hit` and `rsp_miss` set. `rsp_miss` is set when no valid entry holds the requested page number.
- R4: After reset the refill pointer is at slot 0. Each accepted refill writes the slot under the pointer and then moves the pointer to the next slot, wrapping after ENTRIES refills. The oldest mapping is therefore the one replaced.
- R5: A permitted hit sets the entry's referenced bit. `rsp_ref` reports the entry's referenced bit as it was before the access.
- R6: A permitted write hit (`req_kind` = 1) also sets the modified bit. `rsp_mod` reports the modified bit as it was before the access.
- R7: The access kinds are encoded as 0 = read, 1 = write, 2 = execute and 3 = treated as read. Permission bits are bit0 = read, bit1 = write and bit2 = execute. A hit whose kind is not allowed raises `rsp_fault` together with `rsp_hit`, and changes neither the referenced bit nor the modified bit.
- R8: `flush` clears every valid bit in one cycle. A lookup in the same cycle still sees the contents from before the flush. A refill in the same cycle as a flush is discarded.
- R9: If two valid entries hold the same page number, the lower-indexed entry supplies the translation.
- R10: After reset every entry is invalid and `rsp_valid` is low.
- R11: A refill clears the new entry's referenced and modified bits. A lookup in the same cycle as a refill sees the contents from before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| flush | input | 1 | Invalidate all entries |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | VA_W-OFF_W | Page number of the refilled entry |
| fill_pfn | input | PA_W-OFF_W | Frame number of the refilled entry |
| fill_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_miss | output | 1 | No valid entry matched; a refill is needed |
| rsp_fault | output | 1 | Matched, but the access kind is not permitted |
| rsp_paddr | output | PA_W | Translated physical address (zero when there is no hit) |
| rsp_ref | output | 1 | Referenced bit of the matched entry before this access |
| rsp_mod | output | 1 | Modified bit of the matched entry before this access |

## Verification
A lookup can land in the same cycle as a flush, and a lookup can land in the same cycle as a refill. Both cases are provoked by driving the request together with `flush` or `fill_en` on one edge. The lookup is judged to have used the old contents: it still hits across a flush and misses on a page that is only now being loaded. The following request is then judged to see the new state: a miss after the flush, and a hit with a clear referenced bit after the refill. A flush that coincides with a refill is judged by a miss on the page that refill carried.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   localparam int PERM_BITS = 3;
   localparam int PERM_RD   = 0;
   localparam int PERM_WR   = 1;
   localparam int PERM_EX   = 2;

   // Reserved kind is treated as a read.
   function automatic logic access_allowed(input logic [PERM_BITS-1:0] perm,
                                           input acc_kind_e kind);
      case (kind)
         ACC_WRITE: return perm[PERM_WR];
         ACC_FETCH: return perm[PERM_EX];
         default:   return perm[PERM_RD];
      endcase
   endfunction

endpackage

// File: rtl/xlat_fill_ptr.sv
module xlat_fill_ptr #(
   parameter int ENTRIES = 64,
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);

   logic [IDX_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (advance)
         ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
   end

   assign ptr = ptr_q;

   // Round-robin pointer moves on every accepted refill and holds otherwise.
   assert_ptr_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (ptr_q != $past(ptr_q)));
   assert_ptr_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr_q));

endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array import xlat_pkg::*; #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              flush,
   input  logic                              fill_go,
   input  logic [IDX_W-1:0]                  fill_slot,
   input  logic [VPN_W-1:0]                  fill_vpn,
   input  logic [PFN_W-1:0]                  fill_pfn,
   input  logic [PERM_BITS-1:0]              fill_perm,
   input  logic [VPN_W-1:0]                  look_vpn,
   input  logic                              touch_en,
   input  logic [IDX_W-1:0]                  touch_slot,
   input  logic                              touch_dirty,
   output logic [ENTRIES-1:0]                match_vec,
   output logic [ENTRIES-1:0][PFN_W-1:0]     pfn_all,
   output logic [ENTRIES-1:0][PERM_BITS-1:0] perm_all,
   output logic [ENTRIES-1:0]                ref_all,
   output logic [ENTRIES-1:0]                mod_all
);

   for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
      logic                 v_q;
      logic [VPN_W-1:0]     vpn_q;
      logic [PFN_W-1:0]     pfn_q;
      logic [PERM_BITS-1:0] perm_q;
      logic                 r_q;
      logic                 m_q;
      logic                 fill_here;
      logic                 touch_here;

      assign fill_here  = fill_go  && (fill_slot  == IDX_W'(gi));
      assign touch_here = touch_en && (touch_slot == IDX_W'(gi));

      // Priority: flush, then refill, then access update.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q    <= 1'b0;
            vpn_q  <= '0;
            pfn_q  <= '0;
            perm_q <= '0;
            r_q    <= 1'b0;
            m_q    <= 1'b0;
         end else if (flush) begin
            v_q <= 1'b0;
         end else if (fill_here) begin
            v_q    <= 1'b1;
            vpn_q  <= fill_vpn;
            pfn_q  <= fill_pfn;
            perm_q <= fill_perm;
            r_q    <= 1'b0;
            m_q    <= 1'b0;
         end else if (touch_here) begin
            r_q <= 1'b1;
            if (touch_dirty)
               m_q <= 1'b1;
         end
      end

      assign match_vec[gi] = v_q && (vpn_q == look_vpn);
      assign pfn_all[gi]   = pfn_q;
      assign perm_all[gi]  = perm_q;
      assign ref_all[gi]   = r_q;
      assign mod_all[gi]   = m_q;

      assert_valid_from_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(v_q) |-> $past(fill_go && (fill_slot == IDX_W'(gi))));
      assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
         flush |=> !v_q);
      assert_fill_clears_rm_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (fill_go && (fill_slot == IDX_W'(gi)) && !flush) |=> (!r_q && !m_q));
   end

endmodule

// File: rtl/xlat_prio_pick.sv
module xlat_prio_pick #(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);

   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (req[i])
            idx = IDX_W'(i);
   end

   assign any = |req;

   // Checker: no request below the chosen index.
   logic lower_req;
   always_comb begin
      lower_req = 1'b0;
      for (int i = 0; i < ENTRIES; i++)
         if ((i < int'(idx)) && req[i])
            lower_req = 1'b1;
   end

   assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (req[idx] && !lower_req));

endmodule

// File: rtl/vpage_xlat.sv
module vpage_xlat import xlat_pkg::*; #(
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int ENTRIES = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [VA_W-1:0]       req_vaddr,
   input  logic [1:0]            req_kind,
   input  logic                  flush,
   input  logic                  fill_en,
   input  logic [VA_W-OFF_W-1:0] fill_vpn,
   input  logic [PA_W-OFF_W-1:0] fill_pfn,
   input  logic [2:0]            fill_perm,
   output logic                  rsp_valid,
   output logic                  rsp_hit,
   output logic                  rsp_miss,
   output logic                  rsp_fault,
   output logic [PA_W-1:0]       rsp_paddr,
   output logic                  rsp_ref,
   output logic                  rsp_mod
);

   localparam int VPN_W = VA_W - OFF_W;
   localparam int PFN_W = PA_W - OFF_W;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("vpage_xlat: ENTRIES must be at least 2");
   end
   if (OFF_W < 1 || OFF_W >= VA_W || OFF_W >= PA_W) begin : g_bad_offset
      $error("vpage_xlat: OFF_W must leave page and frame bits");
   end

   acc_kind_e                     kind;
   logic [VPN_W-1:0]              look_vpn;
   logic [OFF_W-1:0]              look_off;
   logic [ENTRIES-1:0]            match_vec;
   logic [ENTRIES-1:0][PFN_W-1:0] pfn_all;
   logic [ENTRIES-1:0][PERM_BITS-1:0] perm_all;
   logic [ENTRIES-1:0]            ref_all;
   logic [ENTRIES-1:0]            mod_all;
   logic                          any_hit;
   logic [IDX_W-1:0]              hit_idx;
   logic                          allowed;
   logic                          touch_en;
   logic                          fill_go;
   logic [IDX_W-1:0]              fill_slot;

   assign kind     = acc_kind_e'(req_kind);
   assign look_vpn = req_vaddr[VA_W-1:OFF_W];
   assign look_off = req_vaddr[OFF_W-1:0];
   assign fill_go  = fill_en && !flush;

   xlat_fill_ptr #(.ENTRIES(ENTRIES)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (fill_go),
      .ptr     (fill_slot)
   );

   xlat_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_arr (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .fill_go     (fill_go),
      .fill_slot   (fill_slot),
      .fill_vpn    (fill_vpn),
      .fill_pfn    (fill_pfn),
      .fill_perm   (fill_perm),
      .look_vpn    (look_vpn),
      .touch_en    (touch_en),
      .touch_slot  (hit_idx),
      .touch_dirty (kind == ACC_WRITE),
      .match_vec   (match_vec),
      .pfn_all     (pfn_all),
      .perm_all    (perm_all),
      .ref_all     (ref_all),
      .mod_all     (mod_all)
   );

   xlat_prio_pick #(.ENTRIES(ENTRIES)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (match_vec),
      .any   (any_hit),
      .idx   (hit_idx)
   );

   assign allowed  = access_allowed(perm_all[hit_idx], kind);
   assign touch_en = req_valid && any_hit && allowed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
         rsp_ref   <= 1'b0;
         rsp_mod   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any_hit;
         rsp_miss  <= req_valid && !any_hit;
         rsp_fault <= req_valid && any_hit && !allowed;
         rsp_paddr <= (req_valid && any_hit) ? {pfn_all[hit_idx], look_off} : '0;
         rsp_ref   <= req_valid && any_hit && ref_all[hit_idx];
         rsp_mod   <= req_valid && any_hit && mod_all[hit_idx];
      end
   end

   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_rsp_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault));
   assert_hit_xor_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit ^ rsp_miss));
   assert_fault_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_hit);
   assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && any_hit) |=> (rsp_paddr[OFF_W-1:0] == $past(look_off)));

endmodule

// File: tb/sim_vpage_xlat.sv
module sim_vpage_xlat;

   localparam int VA_W = 32, PA_W = 32, OFF_W = 12, ENTRIES = 64;
   localparam int VPN_W = VA_W - OFF_W, PFN_W = PA_W - OFF_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [VA_W-1:0] req_vaddr = '0;
   logic [1:0] req_kind = '0;
   logic flush = 1'b0;
   logic fill_en = 1'b0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PFN_W-1:0] fill_pfn = '0;
   logic [2:0] fill_perm = '0;
   logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ref, rsp_mod;
   logic [PA_W-1:0] rsp_paddr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vpage_xlat #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .flush(flush), .fill_en(fill_en), .fill_vpn(fill_vpn),
      .fill_pfn(fill_pfn), .fill_perm(fill_perm), .rsp_valid(rsp_valid),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr), .rsp_ref(rsp_ref), .rsp_mod(rsp_mod)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [VA_W-1:0] va(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off);
      return {vpn, off};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0; flush = 1'b0; fill_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Response is registered at the edge after the drive; sampled at the next negedge.
   task automatic acc(input logic [VA_W-1:0] a, input logic [1:0] k);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = a; req_kind = k;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p, input logic [2:0] pm);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = v; fill_pfn = p; fill_perm = pm;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R10 rsp_valid after reset", rsp_valid, 1'b0);
      acc(va(20'h12345, 12'h678), 2'd0);
      chk("R10 empty buffer misses", rsp_miss, 1'b1);
      chk("R3 no hit on empty", rsp_hit, 1'b0);
   endtask

   task automatic t_basic();
      do_reset();
      fill(20'h12345, 20'h0ABCD, 3'b111);
      acc(va(20'h12345, 12'h678), 2'd0);
      chk("R2 rsp_valid", rsp_valid, 1'b1);
      chk("R3 hit", rsp_hit, 1'b1);
      chk("R1 paddr", rsp_paddr, 32'h0ABCD678);
      @(negedge clk);
      chk("R2 rsp_valid single cycle", rsp_valid, 1'b0);
      acc(va(20'h12345, 12'hFFF), 2'd1);
      chk("R1 paddr top offset", rsp_paddr, 32'h0ABCDFFF);
      acc(va(20'h12346, 12'h000), 2'd0);
      chk("R3 neighbour page misses", rsp_miss, 1'b1);
      chk("R3 miss has no hit", rsp_hit, 1'b0);
   endtask

   task automatic t_refmod();
      do_reset();
      fill(20'h00010, 20'h00020, 3'b011);
      acc(va(20'h00010, 12'h004), 2'd0);
      chk("R5 ref clear before first use", rsp_ref, 1'b0);
      chk("R6 mod clear before first use", rsp_mod, 1'b0);
      acc(va(20'h00010, 12'h008), 2'd1);
      chk("R5 ref set by read", rsp_ref, 1'b1);
      chk("R6 mod not set by read", rsp_mod, 1'b0);
      acc(va(20'h00010, 12'h00C), 2'd0);
      chk("R6 mod set by write", rsp_mod, 1'b1);
   endtask

   task automatic t_fault();
      do_reset();
      fill(20'h00030, 20'h00033, 3'b001);
      acc(va(20'h00030, 12'h000), 2'd1);
      chk("R7 write to read-only faults", rsp_fault, 1'b1);
      chk("R7 fault still a hit", rsp_hit, 1'b1);
      acc(va(20'h00030, 12'h000), 2'd2);
      chk("R7 execute without permission faults", rsp_fault, 1'b1);
      acc(va(20'h00030, 12'h000), 2'd0);
      chk("R7 read allowed", rsp_fault, 1'b0);
      chk("R7 faults left ref clear", rsp_ref, 1'b0);
      chk("R7 faults left mod clear", rsp_mod, 1'b0);
      fill(20'h00031, 20'h00034, 3'b100);
      acc(va(20'h00031, 12'h000), 2'd2);
      chk("R7 execute allowed", rsp_fault, 1'b0);
      acc(va(20'h00031, 12'h000), 2'd3);
      chk("R7 kind 3 needs read permission", rsp_fault, 1'b1);
   endtask

   task automatic t_flush();
      do_reset();
      fill(20'h00040, 20'h00044, 3'b111);
      @(negedge clk);
      flush = 1'b1; req_valid = 1'b1; req_vaddr = va(20'h00040, 12'h010); req_kind = 2'd0;
      @(negedge clk);
      flush = 1'b0; req_valid = 1'b0;
      chk("R8 lookup with flush sees old entry", rsp_hit, 1'b1);
      acc(va(20'h00040, 12'h010), 2'd0);
      chk("R8 miss after flush", rsp_miss, 1'b1);
      @(negedge clk);
      flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00041; fill_pfn = 20'h00045; fill_perm = 3'b111;
      @(negedge clk);
      flush = 1'b0; fill_en = 1'b0;
      acc(va(20'h00041, 12'h000), 2'd0);
      chk("R8 refill dropped under flush", rsp_miss, 1'b1);
   endtask

   task automatic t_fill_same();
      do_reset();
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = 20'h00050; fill_pfn = 20'h00055; fill_perm = 3'b111;
      req_valid = 1'b1; req_vaddr = va(20'h00050, 12'h000); req_kind = 2'd0;
      @(negedge clk);
      fill_en = 1'b0; req_valid = 1'b0;
      chk("R11 lookup with refill sees old contents", rsp_miss, 1'b1);
      acc(va(20'h00050, 12'h020), 2'd0);
      chk("R11 hit after refill", rsp_paddr, 32'h00055020);
      chk("R11 refill left ref clear", rsp_ref, 1'b0);
   endtask

   task automatic t_dup();
      do_reset();
      fill(20'h00060, 20'h00111, 3'b111);
      fill(20'h00060, 20'h00222, 3'b111);
      acc(va(20'h00060, 12'h000), 2'd0);
      chk("R9 lower slot wins", rsp_paddr, 32'h00111000);
   endtask

   task automatic t_wrap();
      do_reset();
      for (int i = 0; i < ENTRIES; i++)
         fill(VPN_W'(32'h100 + i), PFN_W'(32'h200 + i), 3'b111);
      acc(va(20'h00105, 12'h001), 2'd0);
      chk("R4 slot 5 mapping", rsp_paddr, 32'h00205001);
      fill(20'h00999, 20'h00777, 3'b111);
      acc(va(20'h00100, 12'h000), 2'd0);
      chk("R4 oldest replaced after wrap", rsp_miss, 1'b1);
      acc(va(20'h00999, 12'h000), 2'd0);
      chk("R4 new mapping present", rsp_paddr, 32'h00777000);
      acc(va(20'h00101, 12'h000), 2'd0);
      chk("R4 second slot kept", rsp_paddr, 32'h00201000);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_refmod();
      t_fault();
      t_flush();
      t_fill_same();
      t_dup();
      t_wrap();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule